// File: doc/BRIEF.md
# Cascadable Up/Down Presettable Counter

This block is a synchronous binary counter built from a parameterised number of identical narrow stages (four bits each by default) chained into one wide counter. Every stage updates on the same rising clock edge, so all output bits change together. A direction input selects counting up or down. An active-low load input presets the whole counter from a parallel data word on the next edge, whatever the count enables are doing.

Counting needs two active-low enables to be low together. The first is the parallel enable, shared by all stages. The second is the trickle enable, which feeds the lowest stage. Each stage drives an active-low terminal-count flag. The flag goes low when that stage's trickle enable is low and the stage is at its end value: all ones when counting up, zero when counting down. That flag becomes the trickle enable of the next stage up, so carries and borrows pass through the chain without extra gating. The flag of the top stage is brought out so that further counters can be chained on. A synchronous active-high reset clears the count for simulation and start-up.

Top module: `updn_cascade`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 after that edge. Reset has priority over load and over counting.
- R2: When `load_n` is 0 (and `rst` is 0), `q` takes the value of `din` at the next rising edge, whatever the levels of `cnt_par_n` and `cnt_trk_n`.
- R3: When `load_n`=1, `cnt_par_n`=0, `cnt_trk_n`=0 and `up`=1, `q` increases by one at each edge. It wraps from all ones to 0.
- R4: When `load_n`=1, `cnt_par_n`=0, `cnt_trk_n`=0 and `up`=0, `q` decreases by one at each edge. It wraps from 0 to all ones.
- R5: When `load_n`=1 and either `cnt_par_n` or `cnt_trk_n` is 1, `q` keeps its value.
- R6: `tc_n` is combinational. It is 0 exactly when `cnt_trk_n`=0 and either (`up`=1 and `q` is all ones) or (`up`=0 and `q`=0). `cnt_par_n` has no effect on it.
- R7: Inside the chain, stage k counts only when every stage below it is at its end value for the current direction. Carries (up) and borrows (down) therefore cross stage boundaries, and the chain behaves as a single counter of STAGES*STAGE_W bits, modulo 2^(STAGES*STAGE_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0 |
| load_n | input | 1 | Active-low synchronous preset from `din` |
| cnt_par_n | input | 1 | Active-low parallel count enable, shared by all stages |
| cnt_trk_n | input | 1 | Active-low trickle count enable into the lowest stage |
| up | input | 1 | 1 = count up, 0 = count down |
| din | input | STAGES*STAGE_W | Preset data |
| q | output | STAGES*STAGE_W | Registered count |
| tc_n | output | 1 | Active-low terminal count of the top stage |

## Verification
The load and the count enables can both be active in the same cycle. The bench holds both enables low while `load_n` is low and expects the preset word after the edge, not that word plus or minus one. Counting and the end-value flag also meet in one cycle: when the count is at all ones going up, the flag is low and the carry into every upper stage happens on the same edge. The bench checks this by comparing the full wide value with a bench model at 0x00F→0x010, at the wrap FFF→000, and at the matching borrow points when counting down.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic    load_n,
  input  logic    par_n,
  input  logic    trk_n,
  input  logic    up,
  output cnt_op_e op
);
  always_comb begin
    if (!load_n)
      op = OP_LOAD;
    else if (!par_n && !trk_n)
      op = up ? OP_INC : OP_DEC;
    else
      op = OP_HOLD;
  end
endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         up,
  input  logic         trk_n,
  output logic         tc_n
);
  logic at_end;
  always_comb begin
    at_end = up ? (&q) : ~(|q);
    tc_n   = ~(at_end & ~trk_n);
  end

  // R6: the flag can only be active while the trickle enable is active
  always_comb begin
    if (trk_n) assert_tc_gated_R6: assert (tc_n);
  end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic         par_n,
  input  logic         trk_n,
  input  logic         up,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc_n
);
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  cnt_op_e op;

  updn_ctrl u_ctrl (
    .load_n (load_n),
    .par_n  (par_n),
    .trk_n  (trk_n),
    .up     (up),
    .op     (op)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD: q <= din;
        OP_INC:  q <= q + STEP;
        OP_DEC:  q <= q - STEP;
        default: q <= q;
      endcase
    end
  end

  updn_tc #(.W(W)) u_tc (
    .q     (q),
    .up    (up),
    .trk_n (trk_n),
    .tc_n  (tc_n)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (q == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (q == $past(din)));

  assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (load_n && !par_n && !trk_n && up) |=> (q == $past(q) + STEP));

  assert_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (load_n && !par_n && !trk_n && !up) |=> (q == $past(q) - STEP));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (load_n && (par_n || trk_n)) |=> $stable(q));
endmodule

// File: rtl/updn_cascade.sv
module updn_cascade #(
  parameter int STAGES  = 3,
  parameter int STAGE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_n,
  input  logic                      cnt_par_n,
  input  logic                      cnt_trk_n,
  input  logic                      up,
  input  logic [STAGES*STAGE_W-1:0] din,
  output logic [STAGES*STAGE_W-1:0] q,
  output logic                      tc_n
);
  localparam int TOTAL_W = STAGES * STAGE_W;

  logic [STAGES:0] trk_chain;
  assign trk_chain[0] = cnt_trk_n;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    updn_stage #(.W(STAGE_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .load_n (load_n),
      .par_n  (cnt_par_n),
      .trk_n  (trk_chain[i]),
      .up     (up),
      .din    (din[i*STAGE_W +: STAGE_W]),
      .q      (q[i*STAGE_W +: STAGE_W]),
      .tc_n   (trk_chain[i+1])
    );
  end

  assign tc_n = trk_chain[STAGES];

  // R7: carry through every stage at the all-ones wrap
  assert_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (load_n && !cnt_par_n && !cnt_trk_n && up && (&q)) |=> (q == '0));

  // R7: borrow through every stage at the zero wrap
  assert_borrow_R7: assert property (@(posedge clk) disable iff (rst)
    (load_n && !cnt_par_n && !cnt_trk_n && !up && (q == '0)) |=> (&q));

  // R6: the top flag follows the full-width end value
  assert_tc_full_R6: assert property (@(posedge clk) disable iff (rst)
    (!cnt_trk_n && up && (&q)) |-> !tc_n);

  logic [TOTAL_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/tb_updn_cascade.sv
`timescale 1ns/1ps
module tb_updn_cascade;
  localparam int STAGES  = 3;
  localparam int STAGE_W = 4;
  localparam int TW      = STAGES * STAGE_W;
  localparam logic [TW-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_n = 1'b1, cnt_par_n = 1'b1, cnt_trk_n = 1'b1, up = 1'b1;
  logic [TW-1:0] din = '0;
  logic [TW-1:0] q;
  logic tc_n;

  int checks = 0;
  int failures = 0;
  logic [TW-1:0] model = '0;

  always #5 clk = ~clk;

  updn_cascade #(.STAGES(STAGES), .STAGE_W(STAGE_W)) dut (
    .clk(clk), .rst(rst), .load_n(load_n), .cnt_par_n(cnt_par_n),
    .cnt_trk_n(cnt_trk_n), .up(up), .din(din), .q(q), .tc_n(tc_n)
  );

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, clock once, update model, sample after edge
  task automatic step(input logic l_n, input logic p_n, input logic t_n,
                      input logic dir, input logic [TW-1:0] d);
    @(negedge clk);
    load_n = l_n; cnt_par_n = p_n; cnt_trk_n = t_n; up = dir; din = d;
    @(posedge clk);
    if (rst) model = '0;
    else if (!l_n) model = d;
    else if (!p_n && !t_n) model = dir ? model + 1'b1 : model - 1'b1;
    #2;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'h5A5);
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'h5A5);
    chk("R1 reset beats load", q, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_load;
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'hA5C);
    chk("R2 load enables off", q, 12'hA5C);
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'h3C7);
    chk("R2 load with enables on, no increment", q, 12'h3C7);
    step(1'b0, 1'b0, 1'b0, 1'b0, 12'h000);
    chk("R2 load with down counting", q, 12'h000);
  endtask

  task automatic t_up;
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h00E);
    step(1'b1, 1'b0, 1'b0, 1'b1, '0);
    chk("R3 increment", q, 12'h00F);
    step(1'b1, 1'b0, 1'b0, 1'b1, '0);
    chk("R7 carry into stage 1", q, 12'h010);
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h0FF);
    step(1'b1, 1'b0, 1'b0, 1'b1, '0);
    chk("R7 carry into stage 2", q, 12'h100);
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFE);
    step(1'b1, 1'b0, 1'b0, 1'b1, '0);
    chk("R3 reach all ones", q, ALL1);
    step(1'b1, 1'b0, 1'b0, 1'b1, '0);
    chk("R3 wrap to zero", q, '0);
  endtask

  task automatic t_down;
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h010);
    step(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk("R7 borrow from stage 1", q, 12'h00F);
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h001);
    step(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk("R4 decrement", q, 12'h000);
    step(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk("R4 wrap to all ones", q, ALL1);
  endtask

  task automatic t_hold;
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h777);
    step(1'b1, 1'b1, 1'b0, 1'b1, '0);
    chk("R5 hold parallel enable off", q, 12'h777);
    step(1'b1, 1'b0, 1'b1, 1'b0, '0);
    chk("R5 hold trickle enable off", q, 12'h777);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h123);
    chk("R5 hold both off, data ignored", q, 12'h777);
  endtask

  task automatic chk_tc(input string tag, input logic exp);
    #1;
    chk(tag, {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, exp});
  endtask

  task automatic t_tc;
    step(1'b0, 1'b1, 1'b1, 1'b1, ALL1);
    cnt_trk_n = 1'b0; cnt_par_n = 1'b1; load_n = 1'b1; up = 1'b1;
    chk_tc("R6 tc low at all ones up, parallel enable off", 1'b0);
    cnt_par_n = 1'b0;
    chk_tc("R6 tc low with parallel enable on", 1'b0);
    cnt_par_n = 1'b1; cnt_trk_n = 1'b1;
    chk_tc("R6 tc high with trickle off", 1'b1);
    cnt_trk_n = 1'b0; up = 1'b0;
    chk_tc("R6 tc high at all ones down", 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b0, '0);
    cnt_trk_n = 1'b0; cnt_par_n = 1'b1; up = 1'b0;
    chk_tc("R6 tc low at zero down", 1'b0);
    up = 1'b1;
    chk_tc("R6 tc high at zero up", 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'h0FF);
    cnt_trk_n = 1'b0; up = 1'b1;
    chk_tc("R6 tc high when only low stages at end", 1'b1);
  endtask

  task automatic t_long;
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'hF80);
    for (int i = 0; i < 300; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, '0);
      chk("R7 long up run", q, model);
    end
    for (int i = 0; i < 300; i++) begin
      step(1'b1, (i % 7) == 3, (i % 5) == 1, 1'b0, '0);
      chk("R7 long down run with gaps", q, model);
    end
  endtask

  initial begin : watchdog
    #1500000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_up();
    t_down();
    t_hold();
    t_tc();
    t_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule